// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple synchronous request port and an external asynchronous static RAM of 65,536 sixteen-bit words. A requester presents a read or write with an address, write data and a two-bit lane mask. The controller latches the request and runs the memory cycle. It produces the active-low chip select, write strobe, output enable and the two lane strobes, and it drives the shared 16-bit data bus only when that is safe. It then returns read data with a one-clock valid pulse.

Each phase of a cycle lasts a whole number of system clocks. The read access, the write pulse and the post-read bus turnaround are set by parameters, each at least one clock. A write has a fixed setup clock before the strobe falls and a fixed hold clock after it rises. The memory commits data on the rising write strobe, and during the hold clock the address, lanes and data stay unchanged. After a read, the output enable stays high for the turnaround period before the controller can drive the bus again.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever `busy` is low, chip select, write strobe, output enable and both lane strobes are high, and the controller does not drive `mem_dq`.
- R2: A request with `req_valid` high while `busy` is low is accepted at that clock edge, and `busy` is high from the next cycle. A read keeps `busy` high for RD_CYC+TA_CYC cycles and a write for WR_CYC+2 cycles.
- R3: A read holds chip select low, output enable low and write strobe high for exactly RD_CYC cycles, with `mem_addr` equal to the accepted address.
- R4: Mask bit 0 enables the lower lane (data bits 7:0, strobe `mem_lb_n` low). Mask bit 1 enables the upper lane (bits 15:8, strobe `mem_ub_n` low). Both lanes, one lane or none may be selected, for reads and for writes. With chip select high, both lane strobes are high.
- R5: Read data is sampled on the last read clock. `rd_valid` is high for exactly one cycle, the cycle after the last read clock, and during it `rd_data` carries the selected lanes with zero in every unselected lane.
- R6: A write has three phases. First, one setup cycle with chip select low and write strobe high. Then WR_CYC cycles with the write strobe low. Last, one hold cycle with the write strobe high again and chip select still low. Address, lane strobes and bus data stay unchanged through all three phases.
- R7: The controller drives `mem_dq` with the accepted write data only during the three write phases, and never while output enable is low.
- R8: After a read, chip select and output enable are high and the bus is undriven for TA_CYC cycles before the controller returns to idle.
- R9: Request inputs that change while `busy` is high have no effect on the cycle in progress or on memory contents.
- R10: The write strobe and the output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held by the requester until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| busy | output | 1 | A memory cycle is in progress |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 16 | Read result, unselected lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
Sixteen addresses, spread across the upper address bits, are each written with all four lane masks. After every write, the word is read back with all four masks. This separates a lane that was written from one that was wrongly written or kept, and a lane that is returned from one that should read as zero. In every cycle of every transaction the strobe pattern is compared with the phase sequence, so a phase that is one clock too long or too short shows up. One write is made while the request inputs are changed during the busy period. Both addresses are then read back to show that the change had no effect.

// File: rtl/sram_lane_pkg.sv
// Shared types for the SRAM lane controller.
package sram_lane_pkg;
    // Sequencer phases: idle, read access, post-read turnaround,
    // write setup, write strobe low, write hold.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_TURN = 3'd2,
        ST_WSET = 3'd3,
        ST_WPUL = 3'd4,
        ST_WHLD = 3'd5
    } seq_state_t;
endpackage

// File: rtl/sram_seq.sv
// Cycle sequencer. Steps through the read or write phases and counts
// each phase length in clocks. Assumes every length parameter is >= 1
// and that start is only raised while the sequencer is idle.
module sram_seq
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_wr,
    output seq_state_t state,
    output seq_state_t state_nxt,
    output logic       rd_last
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                               : ((WR_CYC > TA_CYC) ? WR_CYC : TA_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign rd_last  = (state == ST_RD) && cnt_zero;

    // Next phase and phase counter reload.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt_zero ? cnt : cnt - 1'b1;
        case (state)
            ST_IDLE: if (start) begin
                state_nxt = start_wr ? ST_WSET : ST_RD;
                cnt_nxt   = CNT_W'(RD_CYC - 1);
            end
            ST_RD: if (cnt_zero) begin
                state_nxt = ST_TURN;
                cnt_nxt   = CNT_W'(TA_CYC - 1);
            end
            ST_TURN: if (cnt_zero) state_nxt = ST_IDLE;
            ST_WSET: begin
                state_nxt = ST_WPUL;
                cnt_nxt   = CNT_W'(WR_CYC - 1);
            end
            ST_WPUL: if (cnt_zero) state_nxt = ST_WHLD;
            ST_WHLD: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end
endmodule

// File: rtl/sram_lane_io.sv
// Pin stage. Registers the memory strobes from the sequencer's next
// phase so that every pin changes straight from a flop. It also owns
// the tristate data drivers and the per-lane read capture. Assumes
// lane_sel already carries the mask that is valid for the next phase.
module sram_lane_io
    import sram_lane_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_nxt,
    input  logic              rd_last,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [LANES-1:0]  lane_cap,
    input  logic [DATA_W-1:0] wdata,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [LANES-1:0]  lane_n,
    output logic              drv_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    inout  wire  [DATA_W-1:0] dq
);
    logic sel_nxt, wr_nxt;

    assign sel_nxt = (state_nxt == ST_RD)   || (state_nxt == ST_WSET) ||
                     (state_nxt == ST_WPUL) || (state_nxt == ST_WHLD);
    assign wr_nxt  = (state_nxt == ST_WSET) || (state_nxt == ST_WPUL) ||
                     (state_nxt == ST_WHLD);

    assign dq = drv_en ? wdata : {DATA_W{1'bz}};

    // Control strobes and driver enable, registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n     <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            drv_en   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            ce_n     <= !sel_nxt;
            we_n     <= (state_nxt != ST_WPUL);
            oe_n     <= (state_nxt != ST_RD);
            drv_en   <= wr_nxt;
            rd_valid <= rd_last;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Lane strobe for byte i.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_n[i] <= 1'b1;
            else        lane_n[i] <= !(sel_nxt && lane_sel[i]);
        end

        // Read capture for byte i; unselected lanes read as zero.
        always_ff @(posedge clk) begin
            if (!rst_n)       rd_data[i*8 +: 8] <= '0;
            else if (rd_last) rd_data[i*8 +: 8] <= lane_cap[i] ? dq[i*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
// Top of the asynchronous SRAM controller. Accepts one request when
// idle, latches address, data and lane mask, and hands the cycle to the
// sequencer and the pin stage. Requests seen while busy are ignored;
// the requester holds its request until busy is low.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              busy,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [15:0]       mem_dq
);
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    seq_state_t        state, state_nxt;
    logic              accept, rd_last, drv_en;
    logic [LANES-1:0]  be_q, lane_sel, lane_n;
    logic [DATA_W-1:0] wdata_q;

    assign busy     = (state != ST_IDLE);
    assign accept   = req_valid && !busy;
    assign lane_sel = busy ? be_q : req_be;
    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];

    // Request latch, loaded only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
        end
    end

    sram_seq #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_wr  (req_write),
        .state     (state),
        .state_nxt (state_nxt),
        .rd_last   (rd_last)
    );

    sram_lane_io #(
        .DATA_W (DATA_W)
    ) io_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .rd_last   (rd_last),
        .lane_sel  (lane_sel),
        .lane_cap  (be_q),
        .wdata     (wdata_q),
        .ce_n      (mem_ce_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .lane_n    (lane_n),
        .drv_en    (drv_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .dq        (mem_dq)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
// Protocol checker for sram_lane_ctrl, attached with bind.
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              drv_en
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !drv_en));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R4
    lane_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_lb_n && mem_ub_n));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (!mem_ce_n && $stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !drv_en);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce_n && !drv_en));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .drv_en    (drv_en)
);

// File: tb/sram_lane_ctrl_tb_top.sv
// Bench: a small behavioural SRAM on the pins, a sweep over addresses
// and lane masks, and per-cycle strobe checks.
module sram_lane_ctrl_tb_top;
    localparam int RD_CYC = 2;
    localparam int WR_CYC = 2;
    localparam int TA_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        busy, rd_valid;
    logic [15:0] rd_data, mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    wire  [15:0] mem_dq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [15:0] mem  [256];
    logic [15:0] refm [256];

    always #10 clk = ~clk;

    sram_lane_ctrl #(
        .ADDR_W (16),
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC),
        .TA_CYC (TA_CYC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_lb_n  (mem_lb_n),
        .mem_ub_n  (mem_ub_n),
        .mem_dq    (mem_dq)
    );

    // Memory model: lanes drive only when selected for a read.
    wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (rd_on && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_on && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hzz;

    // Memory model: commit on the rising write strobe.
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] pins();
        return {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n};
    endfunction

    // One write, checked every cycle; intrude changes request inputs while busy.
    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be, input bit intrude);
        logic [4:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        for (int c = 1; c <= WR_CYC + 3; c++) begin
            @(negedge clk);
            if (c == 1) begin
                if (intrude) begin
                    req_addr = a ^ 16'h0040; req_wdata = ~d; req_be = 2'b11;
                end else req_valid = 1'b0;
            end
            if (intrude && c == WR_CYC + 2) req_valid = 1'b0;
            if (c <= WR_CYC + 2) begin
                exp = {1'b0, !(c >= 2 && c <= WR_CYC + 1), 1'b1, !be[1], !be[0]};
                chk(pins() === exp, "R6/R4 write strobes", 32'(pins()), 32'(exp));
                chk(busy === 1'b1, "R2 busy during write", 32'(busy), 32'd1);
                chk(mem_addr === a, "R6/R9 write address held", 32'(mem_addr), 32'(a));
                chk(mem_dq === d, "R7 write data on bus", 32'(mem_dq), 32'(d));
            end else begin
                chk(busy === 1'b0, "R2 write length", 32'(busy), 32'd0);
                chk(pins() === 5'h1f, "R1 idle after write", 32'(pins()), 32'h1f);
            end
        end
        if (be[0]) refm[a[7:0]][7:0]  = d[7:0];
        if (be[1]) refm[a[7:0]][15:8] = d[15:8];
    endtask

    // One read, checked every cycle, data compared against the shadow.
    task automatic do_read(input logic [15:0] a, input logic [1:0] be);
        logic [4:0]  exp;
        logic [15:0] ed;
        ed = {be[1] ? refm[a[7:0]][15:8] : 8'h00, be[0] ? refm[a[7:0]][7:0] : 8'h00};
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        for (int c = 1; c <= RD_CYC + TA_CYC + 1; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (c <= RD_CYC) begin
                exp = {1'b0, 1'b1, 1'b0, !be[1], !be[0]};
                chk(pins() === exp, "R3/R4 read strobes", 32'(pins()), 32'(exp));
                chk(mem_addr === a, "R3 read address", 32'(mem_addr), 32'(a));
                chk(rd_valid === 1'b0, "R5 no early valid", 32'(rd_valid), 32'd0);
            end else if (c <= RD_CYC + TA_CYC) begin
                chk(pins() === 5'h1f, "R8 turnaround strobes", 32'(pins()), 32'h1f);
                chk(busy === 1'b1, "R2/R8 busy in turnaround", 32'(busy), 32'd1);
                chk(rd_valid === (c == RD_CYC + 1), "R5 valid pulse", 32'(rd_valid), 32'(c == RD_CYC + 1));
                if (c == RD_CYC + 1)
                    chk(rd_data === ed, "R5/R4 read data lanes", 32'(rd_data), 32'(ed));
            end else begin
                chk(busy === 1'b0, "R2 read length", 32'(busy), 32'd0);
                chk(rd_valid === 1'b0, "R5 valid single cycle", 32'(rd_valid), 32'd0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = '0; refm[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(pins() === 5'h1f, "R1 reset strobes", 32'(pins()), 32'h1f);
        chk(busy === 1'b0, "R1 reset busy", 32'(busy), 32'd0);
        chk(rd_valid === 1'b0, "R1 reset valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        // R4/R5: sweep addresses and lane masks, writes then reads
        for (int a = 0; a < 16; a++) begin
            for (int wb = 0; wb < 4; wb++) begin
                logic [15:0] ad, dv;
                ad = 16'(a * 16'h1003);
                dv = 16'(a * 16'h1111) ^ 16'(wb * 16'h0F0F) ^ 16'h5A3C;
                do_write(ad, dv, 2'(wb), 1'b0);
                for (int rb = 0; rb < 4; rb++) do_read(ad, 2'(rb));
            end
        end
        // R9: request inputs changed while busy are ignored
        do_write(16'h8020, 16'hBEEF, 2'b01, 1'b1);
        do_read(16'h8020, 2'b11);
        do_read(16'h8060, 2'b11);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule